// File: doc/BRIEF.md
# One-wire controller host register and interrupt unit

This block is the processor-facing half of a one-wire bus controller. A byte-wide host bus (3-bit address, active-low chip enable, active-low read and write strobes) reaches six registers: a command register, a transmit holding buffer that shares its address with the receive buffer, a read-only status register, an interrupt-enable register, a clock-divisor register and a control register. The block keeps the status flags and drives one interrupt pin whose active level is programmable.

Toward the bit engine the block offers a small handshake. A holding buffer waits in front of the engine's shift register. The block pulses `tx_load` when the engine is idle and a byte is pending, and the engine answers with `tx_done` when the byte has left the wire. Single-cycle event inputs report reset completion with its presence result, an unexpected low line, a shorted line, a byte arriving in the receive shift register and a byte ready to move to the receive buffer. The divisor and control contents are handed straight to the engine.

The transmit path is a four-state machine over the pair (holding buffer full, shift register busy). TX_EMPTY goes to TX_HOLD on a host write. TX_HOLD always goes to TX_SHIFT while pulsing `tx_load`, or to TX_BOTH if the host writes in that same cycle. TX_SHIFT goes to TX_EMPTY on `tx_done`, to TX_BOTH on a write, and to TX_HOLD when both arrive together. TX_BOTH goes to TX_HOLD on `tx_done`.

Top module: `owm_host_regs`

## Requirements
- R1: Address 0 is the command register, 1 is transmit (write) and receive buffer (read), 2 is status, 3 is interrupt enable, 4 is clock divisor and 5 is control. Registers 3, 4 and 5 read back what was written. Reads of addresses 6 and 7 return 0x00.
- R2: When both strobes are low with chip enable low, the access is a write and has no read side effect.
- R3: The status bits, from bit 7 to bit 0, are: line low, line short, receive shift full, receive buffer full, transmit shift empty, transmit buffer empty, presence result, presence done. The status value after master reset is 0x0E.
- R4: Presence done, line low and line short clear when status is read; a status read leaves the other flags unchanged. Presence result takes `pres_result` on each `pres_done` pulse and holds otherwise.
- R5: A host write to the transmit buffer clears transmit-buffer-empty. When the byte is handed over (`tx_load`, byte on `tx_byte`), transmit-shift-empty clears and transmit-buffer-empty sets. `tx_done` sets transmit-shift-empty again. Bytes are loaded in write order.
- R6: Receive-buffer-full sets on `rx_done`, which stores `rx_byte` in the receive buffer and clears receive-shift-full. It clears only on a read of address 1. If it is still set and still enabled, the interrupt reasserts one cycle after a status read.
- R7: The interrupt is active one cycle after any status flag whose enable bit (same bit position) is 1. Enable bit 1 has no source; it sets the active level (1 = high, 0 = low). The cycle after a status read, the output is inactive.
- R8: Master reset clears the enable register, so the interrupt pin rests high.
- R9: Command bits are: bit 3 the live `bus_level`, bit 2 force low, bit 1 search enable, bit 0 bus-reset request. Writing bit 0 as 1 clears search enable. The request stays set through later writes until `pres_done`.
- R10: `force_low` is driven only while command bit 2 and control bit 0 are both 1.
- R11: A transmit write while the holding buffer is full replaces the pending byte and leaves the status flags unchanged.
- R12: A register write is visible on the clock edge at which the write strobe is sampled active with chip enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Master reset, active high |
| cs_n | input | 1 | Chip enable, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| irq | output | 1 | Interrupt, programmable level |
| bus_level | input | 1 | Live one-wire line level |
| force_low | output | 1 | Hold the line low directly |
| search_en | output | 1 | Search mode enable to engine |
| reset_req | output | 1 | Bus reset request to engine |
| pres_done | input | 1 | Pulse: bus reset finished |
| pres_result | input | 1 | Presence result with `pres_done` (0 = device found) |
| line_low_ev | input | 1 | Pulse: line low while idle |
| line_short_ev | input | 1 | Pulse: line low before a slot |
| tx_byte | output | 8 | Byte offered to the shift register |
| tx_load | output | 1 | Pulse: engine takes `tx_byte` |
| tx_done | input | 1 | Pulse: shift register emptied |
| rx_shift_set | input | 1 | Pulse: receive shift register full |
| rx_done | input | 1 | Pulse: move `rx_byte` to receive buffer |
| rx_byte | input | 8 | Received byte |
| clk_div | output | 8 | Clock divisor register |
| ctrl_out | output | 8 | Control register |

## Verification
The assertions assume that the engine behaves as a well-formed partner. It pulses `tx_done` only while its shift register is busy, that is after a `tx_load` and before the matching done. It never pulses `rx_shift_set` and `rx_done` in the same cycle. The bench drives every engine pulse for one cycle and orders them as a real engine would. It issues `tx_done` only after a load it has seen, and it raises host strobes for one cycle at a time, so each read side effect occurs exactly once.

// File: rtl/owm_pkg.sv
package owm_pkg;
    localparam int DW = 8;
    localparam int AW = 3;

    localparam logic [AW-1:0] A_CMD  = 3'd0;
    localparam logic [AW-1:0] A_DATA = 3'd1;
    localparam logic [AW-1:0] A_STAT = 3'd2;
    localparam logic [AW-1:0] A_IEN  = 3'd3;
    localparam logic [AW-1:0] A_DIV  = 3'd4;
    localparam logic [AW-1:0] A_CTL  = 3'd5;

    localparam int SB_PD   = 0;
    localparam int SB_PDR  = 1;
    localparam int SB_TBE  = 2;
    localparam int SB_TEMT = 3;
    localparam int SB_RBF  = 4;
    localparam int SB_RSRF = 5;
    localparam int SB_LS   = 6;
    localparam int SB_LL   = 7;

    localparam int IEN_POL      = 1;
    localparam int CTL_FORCE_EN = 0;

    typedef enum logic [1:0] {
        TX_EMPTY,
        TX_HOLD,
        TX_SHIFT,
        TX_BOTH
    } tx_state_e;
endpackage

// File: rtl/owm_tx_hold.sv
module owm_tx_hold
    import owm_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         host_wr,
    input  logic [W-1:0] host_data,
    input  logic         eng_done,
    output logic         tx_load,
    output logic [W-1:0] tx_byte,
    output logic         tbe,
    output logic         temt
);
    tx_state_e state_q, state_d;
    logic [W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= TX_EMPTY;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)          hold_q <= '0;
        else if (host_wr) hold_q <= host_data;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_EMPTY: if (host_wr) state_d = TX_HOLD;
            TX_HOLD:  state_d = host_wr ? TX_BOTH : TX_SHIFT;
            TX_SHIFT: begin
                if (host_wr && eng_done) state_d = TX_HOLD;
                else if (host_wr)        state_d = TX_BOTH;
                else if (eng_done)       state_d = TX_EMPTY;
            end
            TX_BOTH:  if (eng_done) state_d = TX_HOLD;
        endcase
    end

    always_comb begin
        tx_load = (state_q == TX_HOLD);
        tbe     = (state_q == TX_EMPTY) || (state_q == TX_SHIFT);
        temt    = (state_q == TX_EMPTY) || (state_q == TX_HOLD);
        tx_byte = hold_q;
    end
endmodule

// File: rtl/owm_status.sv
module owm_status
    import owm_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stat_rd,
    input  logic         rxbuf_rd,
    input  logic         tbe,
    input  logic         temt,
    input  logic         pres_done,
    input  logic         pres_result,
    input  logic         line_low_ev,
    input  logic         line_short_ev,
    input  logic         rx_shift_set,
    input  logic         rx_done,
    input  logic [W-1:0] ien,
    output logic [W-1:0] status,
    output logic         irq
);
    logic pd_q, pdr_q, ll_q, ls_q, rsrf_q, rbf_q, irq_q;
    logic [W-1:0] src_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_q   <= 1'b0;
            pdr_q  <= 1'b1;
            ll_q   <= 1'b0;
            ls_q   <= 1'b0;
            rsrf_q <= 1'b0;
            rbf_q  <= 1'b0;
        end else begin
            if (pres_done)          pd_q <= 1'b1;
            else if (stat_rd)       pd_q <= 1'b0;
            if (pres_done)          pdr_q <= pres_result;
            if (line_low_ev)        ll_q <= 1'b1;
            else if (stat_rd)       ll_q <= 1'b0;
            if (line_short_ev)      ls_q <= 1'b1;
            else if (stat_rd)       ls_q <= 1'b0;
            if (rx_shift_set)       rsrf_q <= 1'b1;
            else if (rx_done)       rsrf_q <= 1'b0;
            if (rx_done)            rbf_q <= 1'b1;
            else if (rxbuf_rd)      rbf_q <= 1'b0;
        end
    end

    always_comb begin
        status          = '0;
        status[SB_PD]   = pd_q;
        status[SB_PDR]  = pdr_q;
        status[SB_TBE]  = tbe;
        status[SB_TEMT] = temt;
        status[SB_RBF]  = rbf_q;
        status[SB_RSRF] = rsrf_q;
        status[SB_LS]   = ls_q;
        status[SB_LL]   = ll_q;
        src_mask          = ien;
        src_mask[IEN_POL] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)          irq_q <= 1'b0;
        else if (stat_rd) irq_q <= 1'b0;
        else              irq_q <= |(status & src_mask);
    end

    assign irq = ien[IEN_POL] ? irq_q : ~irq_q;
endmodule

// File: rtl/owm_host_regs.sv
module owm_host_regs
    import owm_pkg::*;
#(
    parameter int W = DW,
    parameter int A = AW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_n,
    input  logic         rd_n,
    input  logic         wr_n,
    input  logic [A-1:0] addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         irq,
    input  logic         bus_level,
    output logic         force_low,
    output logic         search_en,
    output logic         reset_req,
    input  logic         pres_done,
    input  logic         pres_result,
    input  logic         line_low_ev,
    input  logic         line_short_ev,
    output logic [W-1:0] tx_byte,
    output logic         tx_load,
    input  logic         tx_done,
    input  logic         rx_shift_set,
    input  logic         rx_done,
    input  logic [W-1:0] rx_byte,
    output logic [W-1:0] clk_div,
    output logic [W-1:0] ctrl_out
);
    logic         wr_acc, rd_acc, stat_rd, rxbuf_rd, dat_wr;
    logic [W-1:0] ien_q, div_q, ctl_q, rxbuf_q, status_w;
    logic         force_q, search_q, rreq_q, tbe_w, temt_w;

    assign wr_acc   = ~cs_n & ~wr_n;
    assign rd_acc   = ~cs_n & ~rd_n & wr_n;
    assign stat_rd  = rd_acc & (addr == A_STAT);
    assign rxbuf_rd = rd_acc & (addr == A_DATA);
    assign dat_wr   = wr_acc & (addr == A_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q <= '0;
            div_q <= '0;
            ctl_q <= '0;
        end else if (wr_acc) begin
            if (addr == A_IEN) ien_q <= wdata;
            if (addr == A_DIV) div_q <= wdata;
            if (addr == A_CTL) ctl_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            force_q  <= 1'b0;
            search_q <= 1'b0;
            rreq_q   <= 1'b0;
        end else begin
            if (wr_acc && addr == A_CMD) begin
                force_q  <= wdata[2];
                search_q <= wdata[0] ? 1'b0 : wdata[1];
            end
            if (wr_acc && addr == A_CMD && wdata[0]) rreq_q <= 1'b1;
            else if (pres_done)                      rreq_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          rxbuf_q <= '0;
        else if (rx_done) rxbuf_q <= rx_byte;
    end

    owm_tx_hold #(.W(W)) u_tx (
        .clk(clk), .rst(rst), .host_wr(dat_wr), .host_data(wdata),
        .eng_done(tx_done), .tx_load(tx_load), .tx_byte(tx_byte),
        .tbe(tbe_w), .temt(temt_w)
    );

    owm_status #(.W(W)) u_stat (
        .clk(clk), .rst(rst), .stat_rd(stat_rd), .rxbuf_rd(rxbuf_rd),
        .tbe(tbe_w), .temt(temt_w), .pres_done(pres_done),
        .pres_result(pres_result), .line_low_ev(line_low_ev),
        .line_short_ev(line_short_ev), .rx_shift_set(rx_shift_set),
        .rx_done(rx_done), .ien(ien_q), .status(status_w), .irq(irq)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            A_CMD:   rdata[3:0] = {bus_level, force_q, search_q, rreq_q};
            A_DATA:  rdata = rxbuf_q;
            A_STAT:  rdata = status_w;
            A_IEN:   rdata = ien_q;
            A_DIV:   rdata = div_q;
            A_CTL:   rdata = ctl_q;
            default: rdata = '0;
        endcase
    end

    assign force_low = force_q & ctl_q[CTL_FORCE_EN];
    assign search_en = search_q;
    assign reset_req = rreq_q;
    assign clk_div   = div_q;
    assign ctrl_out  = ctl_q;
endmodule

// File: rtl/owm_host_regs_chk.sv
module owm_host_regs_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic [2:0] addr,
    input logic [7:0] wdata,
    input logic       irq,
    input logic       search_en,
    input logic       reset_req,
    input logic       pres_done,
    input logic       tx_load,
    input logic [7:0] ien,
    input logic [7:0] status,
    input logic       stat_rd
);
    logic cmd_wr, dat_wr, rx_rd;
    assign cmd_wr = !cs_n && !wr_n && addr == 3'd0;
    assign dat_wr = !cs_n && !wr_n && addr == 3'd1;
    assign rx_rd  = !cs_n && !rd_n && wr_n && addr == 3'd1;

    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
        stat_rd |=> (irq != ien[1])); // R7
    AST_LOAD_TEMT: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> !status[3]); // R5
    AST_LOAD_TBE: assert property (@(posedge clk) disable iff (rst)
        (tx_load && !dat_wr) |=> status[2]); // R5
    AST_RBF_KEEP: assert property (@(posedge clk) disable iff (rst)
        (status[4] && !rx_rd) |=> status[4]); // R6
    AST_RST_CLR_SRCH: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wdata[0]) |=> (reset_req && !search_en)); // R9
    AST_RST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (reset_req && !pres_done) |=> reset_req); // R9
    AST_PDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        !pres_done |=> $stable(status[1])); // R4
endmodule

bind owm_host_regs owm_host_regs_chk u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .irq(irq), .search_en(search_en),
    .reset_req(reset_req), .pres_done(pres_done), .tx_load(tx_load),
    .ien(ien_q), .status(status_w), .stat_rd(stat_rd)
);

// File: tb/owm_host_regs_test.sv
module owm_host_regs_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq, force_low, search_en, reset_req, tx_load;
    logic       bus_level = 1'b1, pres_done = 1'b0, pres_result = 1'b0;
    logic       line_low_ev = 1'b0, line_short_ev = 1'b0;
    logic       tx_done = 1'b0, rx_shift_set = 1'b0, rx_done = 1'b0;
    logic [7:0] rx_byte = '0, tx_byte, clk_div, ctrl_out;

    int tests = 0;
    int fails = 0;
    int loads = 0;
    logic [7:0] rd_exp_q[$];
    string      rd_tag_q[$];
    logic [7:0] tx_exp_q[$];

    always #5 clk = ~clk;

    owm_host_regs uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq),
        .bus_level(bus_level), .force_low(force_low), .search_en(search_en),
        .reset_req(reset_req), .pres_done(pres_done), .pres_result(pres_result),
        .line_low_ev(line_low_ev), .line_short_ev(line_short_ev),
        .tx_byte(tx_byte), .tx_load(tx_load), .tx_done(tx_done),
        .rx_shift_set(rx_shift_set), .rx_done(rx_done), .rx_byte(rx_byte),
        .clk_div(clk_div), .ctrl_out(ctrl_out)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // monitor: host reads and engine loads
    always @(negedge clk) begin
        if (!rst && !cs_n && !rd_n && wr_n) begin
            if (rd_exp_q.size() == 0) check("R1 unexpected read", rdata, 8'hxx);
            else check(rd_tag_q.pop_front(), rdata, rd_exp_q.pop_front());
        end
        if (!rst && tx_load) begin
            loads++;
            if (tx_exp_q.size() == 0) check("R5 unexpected load", tx_byte, 8'hxx);
            else check("R5 loaded byte order", tx_byte, tx_exp_q.pop_front());
        end
    end

    task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        cs_n = 0; wr_n = 0; addr = a; wdata = d;
        @(posedge clk); #1;
        cs_n = 1; wr_n = 1;
    endtask

    task automatic host_rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        rd_exp_q.push_back(exp); rd_tag_q.push_back(tag);
        cs_n = 0; rd_n = 0; addr = a;
        @(posedge clk); #1;
        cs_n = 1; rd_n = 1;
    endtask

    task automatic tx_write(input logic [7:0] d, input bit overwrite);
        if (overwrite) void'(tx_exp_q.pop_back());
        tx_exp_q.push_back(d);
        host_wr(3'd1, d);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_tx_done();
        @(posedge clk); #1; tx_done = 1;
        @(posedge clk); #1; tx_done = 0;
    endtask

    task automatic pulse_rx(input bit shift_evt, input logic [7:0] b);
        @(posedge clk); #1;
        rx_shift_set = shift_evt; rx_done = !shift_evt; rx_byte = b;
        @(posedge clk); #1;
        rx_shift_set = 0; rx_done = 0;
    endtask

    task automatic pulse_pres(input logic res);
        @(posedge clk); #1; pres_done = 1; pres_result = res;
        @(posedge clk); #1; pres_done = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst = 0;
        idle(1);
        // reset state
        check("R8 irq rests high", {7'd0, irq}, 8'h01);
        check("R5 no load after reset", {7'd0, tx_load}, 8'h00);
        host_rd(3'd2, 8'h0E, "R3 status after reset");
        host_rd(3'd3, 8'h00, "R8 enable cleared");
        host_rd(3'd0, 8'h08, "R9 command shows bus level");
        host_rd(3'd6, 8'h00, "R1 unused addr 6");
        host_rd(3'd7, 8'h00, "R1 unused addr 7");

        // register map and write timing
        host_wr(3'd4, 8'h87);
        check("R12 divisor visible after write edge", clk_div, 8'h87);
        host_rd(3'd4, 8'h87, "R1 divisor readback");
        host_wr(3'd5, 8'h01);
        host_rd(3'd5, 8'h01, "R1 control readback");

        // write wins over read
        @(posedge clk); #1;
        cs_n = 0; wr_n = 0; rd_n = 0; addr = 3'd4; wdata = 8'h55;
        @(posedge clk); #1;
        cs_n = 1; wr_n = 1; rd_n = 1;
        host_rd(3'd4, 8'h55, "R2 write wins");

        // transmit path
        tx_write(8'hA5, 0);
        host_rd(3'd2, 8'h06, "R5 byte in shift, buffer empty");
        tx_write(8'h3C, 0);
        host_rd(3'd2, 8'h02, "R5 both full");
        tx_write(8'h7E, 1);
        host_rd(3'd2, 8'h02, "R11 overwrite keeps flags");
        pulse_tx_done();
        host_rd(3'd2, 8'h06, "R5 pending byte moved");
        pulse_tx_done();
        host_rd(3'd2, 8'h0E, "R5 all empty");
        check("R11 two loads only", loads[7:0], 8'd2);

        // receive-full interrupt, active high
        host_wr(3'd3, 8'h12);
        pulse_rx(1, 8'h00);
        host_rd(3'd2, 8'h2E, "R6 receive shift full");
        pulse_rx(0, 8'hC3);
        idle(1);
        check("R7 irq active high", {7'd0, irq}, 8'h01);
        host_rd(3'd2, 8'h1E, "R6 receive buffer full");
        check("R7 status read drops irq", {7'd0, irq}, 8'h00);
        idle(1);
        check("R6 irq fires again", {7'd0, irq}, 8'h01);
        host_rd(3'd1, 8'hC3, "R6 receive buffer data");
        idle(2);
        check("R6 irq gone after service", {7'd0, irq}, 8'h00);
        host_rd(3'd2, 8'h0E, "R6 flag cleared by buffer read");

        // active low
        host_wr(3'd3, 8'h10);
        idle(1);
        check("R7 inactive low-polarity is high", {7'd0, irq}, 8'h01);
        pulse_rx(0, 8'h11);
        idle(1);
        check("R7 active low", {7'd0, irq}, 8'h00);
        host_rd(3'd2, 8'h1E, "R7 status with rbf");
        check("R7 read forces inactive", {7'd0, irq}, 8'h01);
        host_rd(3'd1, 8'h11, "R6 second byte");
        host_wr(3'd3, 8'h00);

        // command register and presence
        host_wr(3'd0, 8'h02);
        check("R9 search enable out", {7'd0, search_en}, 8'h01);
        host_rd(3'd0, 8'h0A, "R9 search set");
        host_wr(3'd0, 8'h03);
        host_rd(3'd0, 8'h09, "R9 reset clears search");
        host_wr(3'd0, 8'h00);
        host_rd(3'd0, 8'h09, "R9 reset request sticky");
        pulse_pres(1'b0);
        host_rd(3'd0, 8'h08, "R9 reset request self-clears");
        host_rd(3'd2, 8'h0D, "R4 presence done with result 0");
        host_rd(3'd2, 8'h0C, "R4 presence done cleared, result kept");

        // line events and unaffected flags
        @(posedge clk); #1; line_low_ev = 1; line_short_ev = 1;
        @(posedge clk); #1; line_low_ev = 0; line_short_ev = 0;
        host_rd(3'd2, 8'hCC, "R4 line flags set");
        host_rd(3'd2, 8'h0C, "R4 line flags cleared by read");
        pulse_rx(1, 8'h00);
        host_rd(3'd2, 8'h2C, "R4 shift full seen");
        host_rd(3'd2, 8'h2C, "R4 shift full survives status read");
        pulse_rx(0, 8'h00);
        host_rd(3'd1, 8'h00, "R6 drain");

        // force low gating
        host_wr(3'd5, 8'h00);
        host_wr(3'd0, 8'h04);
        check("R10 force blocked when disabled", {7'd0, force_low}, 8'h00);
        host_rd(3'd0, 8'h0C, "R9 force bit readback");
        host_wr(3'd5, 8'h01);
        check("R10 force when enabled", {7'd0, force_low}, 8'h01);
        bus_level = 0;
        host_rd(3'd0, 8'h04, "R9 live bus level low");
        host_wr(3'd0, 8'h00);
        check("R10 force released", {7'd0, force_low}, 8'h00);

        idle(2);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule